// File: doc/BRIEF.md
# Serial Command Byte Decoder

This block listens to a serial port made of an active-low select, a serial clock and a data line. It gathers the incoming bits into bytes, decodes each byte that arrives in command position, and sends any data bytes that a command announces to the configuration register they belong to. There are four registers: setup (clock mode, reference mode and differential routing select), a unipolar pair mask, a bipolar pair mask and a GPIO configuration register. One further command announces a multi-byte word for the DAC bank, and the block hands that word over on a one-cycle strobe.

The serial pins are brought into the core clock domain through a synchronizer chain. The decoder tracks whether the next byte is a command or promised data, so a data byte is never decoded as a command. Decoded values are only staged while the select is low. They reach the outputs together when the select is released. A transfer that ends before its promised data is complete leaves the target of that data unchanged.

Top module: `scd_cmd_decoder`

## Requirements
- R1: After reset the clock mode reads 2'b10, the reference mode and differential select read 2'b00, the unipolar, bipolar and GPIO registers read zero, and no DAC strobe is issued.
- R2: A command byte with bit 7 = 0 and bit 6 = 1 is a setup command. Its bits 5:4 load the clock mode, bits 3:2 the reference mode and bits 1:0 the differential select.
- R3: A setup command whose bits 1:0 are 2'b10 makes the next whole byte the unipolar pair mask (bit 7 = pair 0/1, bit 6 = pair 2/3, bit 5 = pair 4/5, bit 4 = pair 6/7).
- R4: A setup command whose bits 1:0 are 2'b11 makes the next whole byte the bipolar pair mask.
- R5: The command byte 8'h03 makes the next whole byte the GPIO configuration register.
- R6: A command byte of the form 0001xxxx announces a DAC word of DAC_BYTES bytes (16 bits by default), received MSB first; its low four bits have no effect. The word appears on dac_wr_data_o together with a one-cycle dac_wr_valid_o pulse after the select is released.
- R7: No output register changes while the select is low; all staged updates appear together after the select rises.
- R8: If the select rises before a promised data byte or word is complete, that target is left unchanged and no DAC strobe is issued. An incomplete command byte has no effect. Bytes completed earlier in the same transfer still take effect.
- R9: Command bytes other than the setup, GPIO (8'h03) and DAC (0001xxxx) encodings change nothing. A setup command with bits 1:0 of 2'b00 or 2'b01 announces no data, so the byte after it is decoded as a command.
- R10: A byte in promised-data position is never decoded as a command, even when its value matches a command encoding.
- R11: One select-low transfer may hold several command/data transactions. After each one completes, the next byte is a command again. When the same register is written twice, the last write wins.
- R12: Data is sampled on rising serial-clock edges, most significant bit first, in groups of eight bits counted from the select falling.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| spi_cs_n | input | 1 | Serial select, active low |
| spi_sclk | input | 1 | Serial clock |
| spi_din | input | 1 | Serial data in |
| clk_mode_o | output | 2 | Clock-mode field of the setup register |
| ref_mode_o | output | 2 | Reference-mode field of the setup register |
| diff_sel_o | output | 2 | Differential routing select field |
| uni_pairs_o | output | 8 | Unipolar pair mask |
| bip_pairs_o | output | 8 | Bipolar pair mask |
| gpio_cfg_o | output | GPIO_W | GPIO configuration register |
| dac_wr_valid_o | output | 1 | One-cycle strobe carrying a DAC word |
| dac_wr_data_o | output | 8*DAC_BYTES | DAC word, first byte in the upper bits |

## Verification
The bench sends a bipolar data byte of 8'h43, which would look like a setup command if decoded as one. A decoder that lost track of the data position would change the clock mode instead of the bipolar mask. Transfers cut short inside a data byte and inside the second DAC byte check that no partial value is committed and no strobe fires. A decoder that committed anyway would corrupt the unipolar mask or emit a bogus DAC word. A single long transfer chains GPIO, setup-with-data and DAC transactions, which shows any failure to return to command position. A mid-transfer probe catches registers that update before the select is released.

// File: rtl/scd_pkg.sv
package scd_pkg;

   typedef enum logic [2:0] {
      ST_CMD,
      ST_UNI,
      ST_BIP,
      ST_GPIO,
      ST_DAC
   } dec_state_t;

   typedef enum logic [1:0] {
      K_NOP,
      K_SETUP,
      K_GPIO,
      K_DAC
   } cmd_kind_t;

   typedef struct packed {
      logic [1:0] clk_mode;
      logic [1:0] ref_mode;
      logic [1:0] diff_sel;
   } setup_t;

   localparam logic [1:0] CLK_MODE_RST = 2'b10;
   localparam logic [1:0] DIFF_TO_UNI  = 2'b10;
   localparam logic [1:0] DIFF_TO_BIP  = 2'b11;
   localparam logic [7:0] GPIO_CMD     = 8'h03;
   localparam logic [3:0] DAC_CMD_HI   = 4'b0001;

   function automatic cmd_kind_t classify(input logic [7:0] b);
      if (b[7:6] == 2'b01)            return K_SETUP;
      else if (b == GPIO_CMD)         return K_GPIO;
      else if (b[7:4] == DAC_CMD_HI)  return K_DAC;
      else                            return K_NOP;
   endfunction

endpackage

// File: rtl/scd_spi_sync.sv
module scd_spi_sync #(
   parameter int STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic cs_n_i,
   input  logic sclk_i,
   input  logic din_i,
   output logic sel_o,
   output logic sck_rise_o,
   output logic cs_rise_o,
   output logic din_o
);
   localparam int TOP = STAGES - 1;

   logic [TOP:0] cs_ff;
   logic [TOP:0] sck_ff;
   logic [TOP:0] din_ff;
   logic         cs_prev;
   logic         sck_prev;

   generate
      for (genvar g = 0; g < STAGES; g++) begin : g_stage
         if (g == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  cs_ff[0]  <= 1'b1;
                  sck_ff[0] <= 1'b0;
                  din_ff[0] <= 1'b0;
               end else begin
                  cs_ff[0]  <= cs_n_i;
                  sck_ff[0] <= sclk_i;
                  din_ff[0] <= din_i;
               end
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) begin
                  cs_ff[g]  <= 1'b1;
                  sck_ff[g] <= 1'b0;
                  din_ff[g] <= 1'b0;
               end else begin
                  cs_ff[g]  <= cs_ff[g-1];
                  sck_ff[g] <= sck_ff[g-1];
                  din_ff[g] <= din_ff[g-1];
               end
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cs_prev  <= 1'b1;
         sck_prev <= 1'b0;
      end else begin
         cs_prev  <= cs_ff[TOP];
         sck_prev <= sck_ff[TOP];
      end
   end

   assign sel_o      = ~cs_ff[TOP];
   assign sck_rise_o = sck_ff[TOP] & ~sck_prev;
   assign cs_rise_o  = cs_ff[TOP] & ~cs_prev;
   assign din_o      = din_ff[TOP];

   AST_CS_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      cs_rise_o |=> !cs_rise_o); // R7

endmodule

// File: rtl/scd_byte_shift.sv
module scd_byte_shift #(
   parameter int BYTE_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_i,
   input  logic              sck_rise_i,
   input  logic              din_i,
   output logic              byte_vld_o,
   output logic [BYTE_W-1:0] byte_o
);
   localparam int CNT_W = $clog2(BYTE_W);
   localparam logic [CNT_W-1:0] LAST = CNT_W'(BYTE_W - 1);

   logic [CNT_W-1:0]  bit_cnt;
   logic [BYTE_W-2:0] sr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bit_cnt    <= '0;
         sr         <= '0;
         byte_vld_o <= 1'b0;
         byte_o     <= '0;
      end else begin
         byte_vld_o <= 1'b0;
         if (!sel_i) begin
            bit_cnt <= '0;
         end else if (sck_rise_i) begin
            sr <= {sr[BYTE_W-3:0], din_i};
            if (bit_cnt == LAST) begin
               bit_cnt    <= '0;
               byte_vld_o <= 1'b1;
               byte_o     <= {sr, din_i};
            end else begin
               bit_cnt <= bit_cnt + 1'b1;
            end
         end
      end
   end

   AST_BYTE_PULSE_ONCE: assert property (@(posedge clk) disable iff (!rst_n)
      byte_vld_o |=> !byte_vld_o); // R12
   AST_IDLE_COUNT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      !sel_i |=> (bit_cnt == '0)); // R8

endmodule

// File: rtl/scd_cmd_fsm.sv
module scd_cmd_fsm
   import scd_pkg::*;
#(
   parameter int DAC_BYTES = 2,
   localparam int DAC_W = 8 * DAC_BYTES
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             byte_vld_i,
   input  logic [7:0]       byte_i,
   input  logic             cs_rise_i,
   output logic             commit_o,
   output logic             setup_v_o,
   output setup_t           setup_o,
   output logic             uni_v_o,
   output logic [7:0]       uni_o,
   output logic             bip_v_o,
   output logic [7:0]       bip_o,
   output logic             gpio_v_o,
   output logic [7:0]       gpio_o,
   output logic             dac_v_o,
   output logic [DAC_W-1:0] dac_o
);
   localparam int IDX_W = (DAC_BYTES > 1) ? $clog2(DAC_BYTES) : 1;
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(DAC_BYTES - 1);

   dec_state_t       state;
   logic [IDX_W-1:0] dac_idx;
   logic [DAC_W-1:0] dac_acc;
   logic [DAC_W-1:0] dac_next;
   cmd_kind_t        kind;

   assign kind = classify(byte_i);

   generate
      if (DAC_BYTES == 1) begin : g_dac_single
         assign dac_next = byte_i;
      end else begin : g_dac_multi
         assign dac_next = {dac_acc[DAC_W-9:0], byte_i};
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state     <= ST_CMD;
         dac_idx   <= '0;
         dac_acc   <= '0;
         setup_v_o <= 1'b0;
         setup_o   <= '0;
         uni_v_o   <= 1'b0;
         uni_o     <= '0;
         bip_v_o   <= 1'b0;
         bip_o     <= '0;
         gpio_v_o  <= 1'b0;
         gpio_o    <= '0;
         dac_v_o   <= 1'b0;
         dac_o     <= '0;
      end else if (cs_rise_i) begin
         state     <= ST_CMD;
         dac_idx   <= '0;
         setup_v_o <= 1'b0;
         uni_v_o   <= 1'b0;
         bip_v_o   <= 1'b0;
         gpio_v_o  <= 1'b0;
         dac_v_o   <= 1'b0;
      end else if (byte_vld_i) begin
         unique case (state)
            ST_CMD: begin
               unique case (kind)
                  K_SETUP: begin
                     setup_v_o <= 1'b1;
                     setup_o   <= setup_t'(byte_i[5:0]);
                     if (byte_i[1:0] == DIFF_TO_UNI)      state <= ST_UNI;
                     else if (byte_i[1:0] == DIFF_TO_BIP) state <= ST_BIP;
                  end
                  K_GPIO: state <= ST_GPIO;
                  K_DAC: begin
                     state   <= ST_DAC;
                     dac_idx <= '0;
                  end
                  default: ;
               endcase
            end
            ST_UNI: begin
               uni_v_o <= 1'b1;
               uni_o   <= byte_i;
               state   <= ST_CMD;
            end
            ST_BIP: begin
               bip_v_o <= 1'b1;
               bip_o   <= byte_i;
               state   <= ST_CMD;
            end
            ST_GPIO: begin
               gpio_v_o <= 1'b1;
               gpio_o   <= byte_i;
               state    <= ST_CMD;
            end
            ST_DAC: begin
               dac_acc <= dac_next;
               if (dac_idx == IDX_LAST) begin
                  dac_v_o <= 1'b1;
                  dac_o   <= dac_next;
                  state   <= ST_CMD;
               end else begin
                  dac_idx <= dac_idx + 1'b1;
               end
            end
            default: state <= ST_CMD;
         endcase
      end
   end

   assign commit_o = cs_rise_i;

   AST_RETURN_TO_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      cs_rise_i |=> (state == ST_CMD)); // R11
   AST_ABORT_DROPS_DAC: assert property (@(posedge clk) disable iff (!rst_n)
      cs_rise_i |=> !dac_v_o); // R8
   AST_DATA_NOT_DECODED: assert property (@(posedge clk) disable iff (!rst_n)
      (byte_vld_i && !cs_rise_i && state == ST_BIP) |=> (bip_v_o && $stable(setup_o))); // R10

endmodule

// File: rtl/scd_cmd_decoder.sv
module scd_cmd_decoder
   import scd_pkg::*;
#(
   parameter int SYNC_STAGES = 2,
   parameter int GPIO_W      = 8,
   parameter int DAC_BYTES   = 2,
   localparam int DAC_W      = 8 * DAC_BYTES
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              spi_cs_n,
   input  logic              spi_sclk,
   input  logic              spi_din,
   output logic [1:0]        clk_mode_o,
   output logic [1:0]        ref_mode_o,
   output logic [1:0]        diff_sel_o,
   output logic [7:0]        uni_pairs_o,
   output logic [7:0]        bip_pairs_o,
   output logic [GPIO_W-1:0] gpio_cfg_o,
   output logic              dac_wr_valid_o,
   output logic [DAC_W-1:0]  dac_wr_data_o
);
   generate
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if (GPIO_W < 1 || GPIO_W > 8) begin : g_bad_gpio
         $error("GPIO_W must lie in 1..8");
      end
      if (DAC_BYTES < 1 || DAC_BYTES > 4) begin : g_bad_dac
         $error("DAC_BYTES must lie in 1..4");
      end
   endgenerate

   logic             sel, sck_rise, cs_rise, din_s;
   logic             byte_vld;
   logic [7:0]       byte_q;
   logic             commit;
   logic             setup_v, uni_v, bip_v, gpio_v, dac_v;
   setup_t           setup_stg;
   logic [7:0]       uni_stg, bip_stg, gpio_stg;
   logic [DAC_W-1:0] dac_stg;
   logic [GPIO_W-1:0] gpio_next;
   setup_t           setup_q;

   scd_spi_sync #(.STAGES(SYNC_STAGES)) i_sync (
      .clk(clk), .rst_n(rst_n),
      .cs_n_i(spi_cs_n), .sclk_i(spi_sclk), .din_i(spi_din),
      .sel_o(sel), .sck_rise_o(sck_rise), .cs_rise_o(cs_rise), .din_o(din_s)
   );

   scd_byte_shift #(.BYTE_W(8)) i_shift (
      .clk(clk), .rst_n(rst_n),
      .sel_i(sel), .sck_rise_i(sck_rise), .din_i(din_s),
      .byte_vld_o(byte_vld), .byte_o(byte_q)
   );

   scd_cmd_fsm #(.DAC_BYTES(DAC_BYTES)) i_fsm (
      .clk(clk), .rst_n(rst_n),
      .byte_vld_i(byte_vld), .byte_i(byte_q), .cs_rise_i(cs_rise),
      .commit_o(commit),
      .setup_v_o(setup_v), .setup_o(setup_stg),
      .uni_v_o(uni_v), .uni_o(uni_stg),
      .bip_v_o(bip_v), .bip_o(bip_stg),
      .gpio_v_o(gpio_v), .gpio_o(gpio_stg),
      .dac_v_o(dac_v), .dac_o(dac_stg)
   );

   generate
      if (GPIO_W == 8) begin : g_gpio_full
         assign gpio_next = gpio_stg;
      end else begin : g_gpio_part
         assign gpio_next = gpio_stg[GPIO_W-1:0];
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         setup_q        <= '{clk_mode: CLK_MODE_RST, ref_mode: 2'b00, diff_sel: 2'b00};
         uni_pairs_o    <= '0;
         bip_pairs_o    <= '0;
         gpio_cfg_o     <= '0;
         dac_wr_valid_o <= 1'b0;
         dac_wr_data_o  <= '0;
      end else begin
         dac_wr_valid_o <= commit & dac_v;
         if (commit) begin
            if (setup_v) setup_q     <= setup_stg;
            if (uni_v)   uni_pairs_o <= uni_stg;
            if (bip_v)   bip_pairs_o <= bip_stg;
            if (gpio_v)  gpio_cfg_o  <= gpio_next;
            if (dac_v)   dac_wr_data_o <= dac_stg;
         end
      end
   end

   assign clk_mode_o = setup_q.clk_mode;
   assign ref_mode_o = setup_q.ref_mode;
   assign diff_sel_o = setup_q.diff_sel;

   AST_HOLD_WHILE_SELECTED: assert property (@(posedge clk) disable iff (!rst_n)
      !commit |=> ($stable(setup_q) && $stable(uni_pairs_o) && $stable(bip_pairs_o)
                   && $stable(gpio_cfg_o))); // R7
   AST_DAC_STROBE_ON_COMMIT: assert property (@(posedge clk) disable iff (!rst_n)
      dac_wr_valid_o |-> $past(commit)); // R6
   AST_DAC_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
      dac_wr_valid_o |=> !dac_wr_valid_o); // R6

endmodule

// File: tb/test_scd_cmd_decoder.sv
module test_scd_cmd_decoder;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cs_n = 1'b1;
   logic        sclk = 1'b0;
   logic        din = 1'b0;
   logic [1:0]  clk_mode, ref_mode, diff_sel;
   logic [7:0]  uni, bip, gpio;
   logic        dac_vld;
   logic [15:0] dac_data;

   int total = 0;
   int bad = 0;

   always #5 clk = ~clk;

   scd_cmd_decoder i_scd_cmd_decoder (
      .clk(clk), .rst_n(rst_n),
      .spi_cs_n(cs_n), .spi_sclk(sclk), .spi_din(din),
      .clk_mode_o(clk_mode), .ref_mode_o(ref_mode), .diff_sel_o(diff_sel),
      .uni_pairs_o(uni), .bip_pairs_o(bip), .gpio_cfg_o(gpio),
      .dac_wr_valid_o(dac_vld), .dac_wr_data_o(dac_data)
   );

   typedef struct packed {
      logic [1:0]  cm;
      logic [1:0]  rm;
      logic [1:0]  ds;
      logic [7:0]  un;
      logic [7:0]  bp;
      logic [7:0]  gp;
      logic [7:0]  dn;
      logic [15:0] dd;
   } exp_t;

   exp_t  model;
   exp_t  exp_q[$];
   string tag_q[$];
   int    dac_seen = 0;
   logic [15:0] dac_last = '0;

   task automatic chk(input string tag, input string what, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s %s: actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   always @(negedge clk) begin
      if (dac_vld) begin
         dac_seen++;
         dac_last = dac_data;
      end
   end

   // Monitor: pops expected items and compares them with the ports.
   initial begin
      forever begin
         @(negedge clk);
         if (exp_q.size() > 0) begin
            exp_t e;
            string t;
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            chk(t, "clk_mode", int'(clk_mode), int'(e.cm));
            chk(t, "ref_mode", int'(ref_mode), int'(e.rm));
            chk(t, "diff_sel", int'(diff_sel), int'(e.ds));
            chk(t, "uni", int'(uni), int'(e.un));
            chk(t, "bip", int'(bip), int'(e.bp));
            chk(t, "gpio", int'(gpio), int'(e.gp));
            chk(t, "dac strobes", dac_seen, int'(e.dn));
            if (e.dn != 0) chk(t, "dac word", int'(dac_last), int'(e.dd));
            dac_seen = 0;
         end
      end
   end

   task automatic push_exp(input string tag);
      exp_q.push_back(model);
      tag_q.push_back(tag);
      repeat (4) @(negedge clk);
      model.dn = 8'd0;
   endtask

   task automatic spi_bit(input logic b);
      @(negedge clk);
      din = b;
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
      sclk = 1'b0;
   endtask

   task automatic spi_byte(input logic [7:0] b, input int nbits = 8);
      for (int i = 0; i < nbits; i++) spi_bit(b[7-i]);
   endtask

   task automatic cs_low();
      @(negedge clk);
      cs_n = 1'b0;
      repeat (4) @(negedge clk);
   endtask

   task automatic cs_high();
      repeat (4) @(negedge clk);
      cs_n = 1'b1;
      repeat (12) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      bad++;
      total++;
      $display("FAIL watchdog: actual=expired expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      model = '{cm: 2'b10, rm: 2'b00, ds: 2'b00, un: 8'h00, bp: 8'h00,
                gp: 8'h00, dn: 8'd0, dd: 16'h0000};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      repeat (4) @(negedge clk);
      push_exp("R1 reset");

      // R2 setup fields
      cs_low(); spi_byte(8'h7C); cs_high();
      model.cm = 2'b11; model.rm = 2'b11; model.ds = 2'b00;
      push_exp("R2 setup");

      // R3 unipolar data, MSB first per R12; R7 no change before release
      cs_low(); spi_byte(8'h62); spi_byte(8'hA5);
      repeat (12) @(negedge clk);
      chk("R7", "uni before release", int'(uni), 0);
      chk("R7", "clk_mode before release", int'(clk_mode), 3);
      cs_high();
      model.cm = 2'b10; model.rm = 2'b00; model.ds = 2'b10; model.un = 8'hA5;
      push_exp("R3 R12 unipolar");

      // R4 bipolar data; R10 byte 0x43 must not act as setup
      cs_low(); spi_byte(8'h53); spi_byte(8'h43); cs_high();
      model.cm = 2'b01; model.rm = 2'b00; model.ds = 2'b11; model.bp = 8'h43;
      push_exp("R4 R10 bipolar");

      // R5 GPIO configuration
      cs_low(); spi_byte(8'h03); spi_byte(8'h5A); cs_high();
      model.gp = 8'h5A;
      push_exp("R5 gpio");

      // R6 DAC word, low nibble of command ignored
      cs_low(); spi_byte(8'h1F); spi_byte(8'hBE); spi_byte(8'hEF); cs_high();
      model.dn = 8'd1; model.dd = 16'hBEEF;
      push_exp("R6 dac");

      // R8 abort inside unipolar data byte: setup commits, mask stays
      cs_low(); spi_byte(8'h62); spi_byte(8'hF0, 4); cs_high();
      model.cm = 2'b10; model.rm = 2'b00; model.ds = 2'b10;
      push_exp("R8 abort uni");

      // R8 abort inside second DAC byte: no strobe
      cs_low(); spi_byte(8'h10); spi_byte(8'h12); spi_byte(8'h34, 4); cs_high();
      push_exp("R8 abort dac");

      // R9 unlisted commands
      cs_low(); spi_byte(8'hFF); spi_byte(8'h00); spi_byte(8'h20); spi_byte(8'h8E); cs_high();
      push_exp("R9 nop");

      // R9 setup without data: next byte is a command
      cs_low(); spi_byte(8'h61); spi_byte(8'h03); spi_byte(8'h77); cs_high();
      model.ds = 2'b01; model.gp = 8'h77;
      push_exp("R9 setup no data");

      // R11 chained transactions in one transfer
      cs_low();
      spi_byte(8'h03); spi_byte(8'h11);
      spi_byte(8'h62); spi_byte(8'h3C);
      spi_byte(8'h1A); spi_byte(8'h12); spi_byte(8'h34);
      cs_high();
      model.gp = 8'h11; model.ds = 2'b10; model.un = 8'h3C;
      model.dn = 8'd1; model.dd = 16'h1234;
      push_exp("R11 chained");

      // R8 incomplete command byte
      cs_low(); spi_byte(8'h7F, 5); cs_high();
      push_exp("R8 partial command");

      // R11 last write wins
      cs_low(); spi_byte(8'h03); spi_byte(8'h21); spi_byte(8'h03); spi_byte(8'h42); cs_high();
      model.gp = 8'h42;
      push_exp("R11 last wins");

      repeat (8) @(negedge clk);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule